// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Pulse Generator

This block is a clocked monostable pulse generator. Five asynchronous control pins are combined into one gated trigger condition: two active-low triggers, two active-high triggers and an active-low clear. The condition is true when at least one active-low trigger is low, both active-high triggers are high and clear is high. Each low-to-high change of this condition starts a pulse on `q`, and `q_n` always carries the inverse of `q`. The pulse length is a number of clock cycles, read from the `width` input at the moment of triggering and timed by a down-counter.

A new trigger edge that arrives during a pulse reloads the counter. Steady retriggering can therefore hold `q` high without a gap. Pulling clear low ends a pulse at once and blocks new ones. Releasing clear counts as a trigger edge when the other inputs already allow one. Each pin passes through a multi-stage synchroniser before it is used. A trigger input change therefore shows on `q` three clocks later with the default two stages, and a clear assertion shows two clocks later.

Top module: `retrig_oneshot`

## Requirements
- R1: While the synchronised clear is low, `q` is low and no pulse can start; `q` falls two clocks after `clear_n` falls, whatever the trigger pins do.
- R2: While both `trig_lo_a` and `trig_lo_b` are high, no edge on any other pin starts a pulse.
- R3: While either `trig_hi_a` or `trig_hi_b` is low, no edge on any other pin starts a pulse.
- R4: A pulse starts when the gate `(NOT(lo_a AND lo_b)) AND hi_a AND hi_b AND clear_n` goes from 0 to 1. This happens when an active-low pin falls or an active-high pin rises. `q` is high from the third clock edge after the pin change.
- R5: A rising `clear_n` starts a pulse when at least one active-low trigger is low and both active-high triggers are high.
- R6: A pulse lasts exactly `width` clock cycles, and a `width` of 0 gives one cycle. `width` is sampled only at the trigger, so changing it during a pulse has no effect on that pulse.
- R7: A trigger edge during a pulse reloads the full width, so the pulse ends `width` cycles after the retrigger.
- R8: Clear going low during a pulse ends that pulse early, two clocks after `clear_n` falls.
- R9: `q_n` is always the complement of `q`.
- R10: Synchronous reset clears the counter and the trigger history. `q` is low during reset, and releasing reset with the trigger gate already true starts no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_lo_a | input | 1 | Active-low trigger A (asynchronous) |
| trig_lo_b | input | 1 | Active-low trigger B (asynchronous) |
| trig_hi_a | input | 1 | Active-high trigger A (asynchronous) |
| trig_hi_b | input | 1 | Active-high trigger B (asynchronous) |
| clear_n | input | 1 | Active-low clear, which also acts as a trigger on release (asynchronous) |
| width | input | WIDTH_BITS | Pulse length in clock cycles, with 0 read as 1 |
| q | output | 1 | Pulse output |
| q_n | output | 1 | Complement of `q` |

## Verification
The bench builds the block with a 4-bit `width` and the default two synchroniser stages. With these values every pulse length, including the 0-to-1 substitution, can be swept for each of the five ways of raising the trigger gate. The expected start cycle and end cycle of every pulse are computed from the three-clock latency and the programmed length. The short widths also keep the retrigger, clear-abort, clear-release and reset-release cases brief enough to check cycle by cycle.

// File: rtl/osh_pkg.sv
package osh_pkg;

   // Synchronised view of the five control pins
   typedef struct packed {
      logic lo_a;
      logic lo_b;
      logic hi_a;
      logic hi_b;
      logic clr_n;
   } trig_in_t;

   localparam int TRIG_PINS = $bits(trig_in_t);

   // Reset image: gate already true, so leaving reset cannot form an edge
   localparam trig_in_t TRIG_RESET = '{lo_a: 1'b0, lo_b: 1'b0, hi_a: 1'b1,
                                       hi_b: 1'b1, clr_n: 1'b1};

endpackage

// File: rtl/osh_sync.sv
module osh_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("osh_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("osh_sync: W must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (rst) chain <= {STAGES{RST_VAL[i]}};
         else     chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end

endmodule

// File: rtl/osh_trig_gate.sv
module osh_trig_gate
   import osh_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  trig_in_t s,
   output logic     fire
);

   logic gate_now;
   logic gate_prev;

   assign gate_now = ~(s.lo_a & s.lo_b) & s.hi_a & s.hi_b & s.clr_n;

   // History resets to "true" so no edge appears right after reset
   always_ff @(posedge clk) begin
      if (rst) gate_prev <= 1'b1;
      else     gate_prev <= gate_now;
   end

   assign fire = gate_now & ~gate_prev;

endmodule

// File: rtl/osh_pulse_timer.sv
module osh_pulse_timer #(
   parameter int WIDTH_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  clr_n,
   input  logic                  fire,
   input  logic [WIDTH_BITS-1:0] width,
   output logic [WIDTH_BITS-1:0] cnt,
   output logic                  busy
);

   localparam logic [WIDTH_BITS-1:0] ONE = WIDTH_BITS'(1);

   logic [WIDTH_BITS-1:0] load_val;

   assign load_val = (width == '0) ? ONE : width;

   always_ff @(posedge clk) begin
      if (rst)             cnt <= '0;
      else if (!clr_n)     cnt <= '0;
      else if (fire)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - ONE;
   end

   assign busy = (cnt != '0);

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
   import osh_pkg::*;
#(
   parameter int WIDTH_BITS  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  trig_lo_a,
   input  logic                  trig_lo_b,
   input  logic                  trig_hi_a,
   input  logic                  trig_hi_b,
   input  logic                  clear_n,
   input  logic [WIDTH_BITS-1:0] width,
   output logic                  q,
   output logic                  q_n
);

   generate
      if (WIDTH_BITS < 1 || WIDTH_BITS > 32) begin : g_bad_bits
         $error("retrig_oneshot: WIDTH_BITS must lie in 1..32");
      end
   endgenerate

   trig_in_t              raw_in;
   trig_in_t              s_in;
   logic                  trig_edge;
   logic [WIDTH_BITS-1:0] cnt;
   logic                  busy;

   assign raw_in = '{lo_a: trig_lo_a, lo_b: trig_lo_b, hi_a: trig_hi_a,
                     hi_b: trig_hi_b, clr_n: clear_n};

   osh_sync #(
      .W       (TRIG_PINS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (TRIG_RESET)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_in),
      .q   (s_in)
   );

   osh_trig_gate u_gate (
      .clk  (clk),
      .rst  (rst),
      .s    (s_in),
      .fire (trig_edge)
   );

   osh_pulse_timer #(
      .WIDTH_BITS (WIDTH_BITS)
   ) u_timer (
      .clk   (clk),
      .rst   (rst),
      .clr_n (s_in.clr_n),
      .fire  (trig_edge),
      .width (width),
      .cnt   (cnt),
      .busy  (busy)
   );

   // Clear overrides the count without waiting for the counter to empty
   assign q   = busy & s_in.clr_n;
   assign q_n = ~q;

endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk
   import osh_pkg::*;
#(
   parameter int WIDTH_BITS = 8
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  q,
   input logic                  q_n,
   input logic [WIDTH_BITS-1:0] width,
   input trig_in_t              s_in,
   input logic                  trig_edge,
   input logic [WIDTH_BITS-1:0] cnt
);

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      !s_in.clr_n |=> (cnt == '0));                                              // R1
   AST_CLR_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
      !s_in.clr_n |-> !trig_edge);                                               // R8
   AST_LO_INHIBIT: assert property (@(posedge clk) disable iff (rst)
      (s_in.lo_a && s_in.lo_b) |-> !trig_edge);                                  // R2
   AST_HI_INHIBIT: assert property (@(posedge clk) disable iff (rst)
      (!s_in.hi_a || !s_in.hi_b) |-> !trig_edge);                                // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cnt == '0 && !trig_edge) |=> (cnt == '0));                                // R4
   AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
      trig_edge |=> (cnt == (($past(width) == '0) ? WIDTH_BITS'(1) : $past(width)))); // R7
   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
      (!trig_edge && s_in.clr_n && cnt != '0) |=> (cnt == $past(cnt) - WIDTH_BITS'(1))); // R6
   AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
      (q ^ q_n));                                                                // R9
   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (cnt == '0 && !q));                                                // R10

endmodule

bind retrig_oneshot retrig_oneshot_chk #(.WIDTH_BITS(WIDTH_BITS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .q         (q),
   .q_n       (q_n),
   .width     (width),
   .s_in      (s_in),
   .trig_edge (trig_edge),
   .cnt       (cnt)
);

// File: tb/retrig_oneshot_test.sv
module retrig_oneshot_test;

   localparam int WB = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          la = 1'b0, lb = 1'b1, ha = 1'b1, hb = 1'b1, cl = 1'b1;
   logic [WB-1:0] width = '0;
   logic          q, q_n;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   retrig_oneshot #(.WIDTH_BITS(WB), .SYNC_STAGES(2)) uut (
      .clk (clk), .rst (rst),
      .trig_lo_a (la), .trig_lo_b (lb), .trig_hi_a (ha), .trig_hi_b (hb),
      .clear_n (cl), .width (width), .q (q), .q_n (q_n)
   );

   task automatic chk(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic expect_q(input string req, input logic exp);
      chk(req, q, exp);
      chk("R9", q_n, ~exp);
   endtask

   task automatic nxt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_in(input logic a, input logic b, input logic c,
                         input logic d, input logic e);
      la = a; lb = b; ha = c; hb = d; cl = e;
   endtask

   task automatic quiet(input string req, input int n);
      for (int k = 0; k < n; k++) begin
         nxt(1);
         expect_q(req, 1'b0);
      end
   endtask

   initial begin
      nxt(4);
      expect_q("R10", 1'b0);
      // leave reset with the gate already true: no pulse may follow
      rst = 1'b0;
      quiet("R10", 8);

      // sweep every width over every trigger source
      for (int w = 0; w < 16; w++) begin
         for (int src = 0; src < 5; src++) begin
            int    eff;
            string rq;
            eff = (w == 0) ? 1 : w;
            rq  = (src == 4) ? "R5" : "R4";
            width = WB'(w);
            case (src)
               0, 1:    set_in(1, 1, 1, 1, 1);
               2:       set_in(0, 1, 0, 1, 1);
               3:       set_in(0, 1, 1, 0, 1);
               default: set_in(0, 1, 1, 1, 0);
            endcase
            nxt(5);
            expect_q(rq, 1'b0);
            case (src)
               0:       la = 1'b0;
               1:       lb = 1'b0;
               2:       ha = 1'b1;
               3:       hb = 1'b1;
               default: cl = 1'b1;
            endcase
            nxt(2);
            expect_q(rq, 1'b0);
            nxt(1);
            for (int k = 0; k < eff; k++) begin
               expect_q(rq, 1'b1);
               nxt(1);
            end
            expect_q("R6", 1'b0);
         end
      end

      // R6: width changed mid-pulse is ignored
      width = 4'd6; set_in(1, 1, 1, 1, 1); nxt(5);
      la = 1'b0; nxt(3);
      for (int k = 0; k < 6; k++) begin
         if (k == 1) width = 4'd2;
         expect_q("R6", 1'b1);
         nxt(1);
      end
      expect_q("R6", 1'b0);

      // R7: retrigger through trig_hi_b extends the pulse
      width = 4'd5; set_in(1, 1, 1, 1, 1); nxt(5);
      la = 1'b0;          // relative negedge 0
      nxt(2); hb = 1'b0;  // negedge 2
      nxt(1); hb = 1'b1;  // negedge 3
      for (int k = 3; k <= 10; k++) begin
         expect_q("R7", 1'b1);
         nxt(1);
      end
      expect_q("R7", 1'b0);

      // R8 then R5: clear cuts a pulse, its release fires a new one
      width = 4'd10; set_in(1, 1, 1, 1, 1); nxt(5);
      la = 1'b0;                            // negedge 0
      nxt(5); cl = 1'b0;                    // negedge 5
      expect_q("R8", 1'b1); nxt(1);         // 6
      expect_q("R8", 1'b1); nxt(1);         // 7
      expect_q("R8", 1'b0); nxt(1);         // 8
      expect_q("R8", 1'b0); nxt(1);         // 9
      cl = 1'b1;
      nxt(2); expect_q("R5", 1'b0);         // 11
      nxt(1);                               // 12
      for (int k = 0; k < 10; k++) begin
         expect_q("R5", 1'b1);
         nxt(1);
      end
      expect_q("R5", 1'b0);

      // R1: clear held low blocks every trigger source
      width = 4'd3; set_in(1, 1, 0, 0, 0); nxt(5);
      la = 1'b0; quiet("R1", 2);
      ha = 1'b1; quiet("R1", 2);
      hb = 1'b1; quiet("R1", 6);
      set_in(1, 1, 1, 1, 0); nxt(4);
      lb = 1'b0; quiet("R1", 6);

      // R2: both active-low pins high
      set_in(1, 1, 0, 0, 0); nxt(5);
      ha = 1'b1; quiet("R2", 3);
      hb = 1'b1; quiet("R2", 3);
      cl = 1'b1; quiet("R2", 6);

      // R3: an active-high pin low
      set_in(1, 1, 1, 0, 1); nxt(5);
      la = 1'b0; quiet("R3", 6);
      set_in(1, 1, 0, 1, 0); nxt(5);
      lb = 1'b0; quiet("R3", 3);
      cl = 1'b1; quiet("R3", 6);

      // R10: reset mid-pulse drops q
      width = 4'd12; set_in(1, 1, 1, 1, 1); nxt(5);
      la = 1'b0; nxt(4);
      expect_q("R10", 1'b1);
      rst = 1'b1; nxt(1);
      expect_q("R10", 1'b0);
      rst = 1'b0; quiet("R10", 6);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule